// File: doc/BRIEF.md
# Paired-Stream Element Combiner

The block reads two operand vectors, one from each of two AXI4-Stream inputs. It combines each pair of elements taken at the same index and sends the result vector out on one AXI4-Stream output. Elements are 32-bit unsigned words. A build-time parameter picks the operation. In the add variant each result is the sum of its two operands. In the multiply variant each result is their product. Either way the result keeps only its low 32 bits. Both variants have the same ports and the same registers, so one can replace the other without any change to the logic around it.

Software controls a run through a small AXI4-Lite slave. It first writes the element count to the length register, then writes a 1 to the start bit. The block takes one beat from each input at the same moment and produces one result beat for each pair. It raises TLAST on the final result beat, then drops back to idle and reports completion. The end of a run is set by the length register alone. The inputs carry no TLAST.

Top module: `elemwise_engine`

## Requirements
- R1: After a synchronous active-low reset, `c_tvalid` is 0 and the control register at offset 0x00 reads 0x4: bit 2 (idle) is 1, bit 1 (done) is 0, bit 0 (busy) is 0.
- R2: A write to offset 0x10 sets the length register, and a read of 0x10 returns the value written.
- R3: Result beat i carries `A[i] + B[i]` when `USE_MUL` is 0 and `A[i] * B[i]` when `USE_MUL` is 1, in both cases truncated to 32 bits.
- R4: A beat is taken from an input only in a cycle where a beat is also taken from the other input. An input whose partner has no valid data sees its ready signal stay low.
- R5: While `c_tvalid` is high and `c_tready` is low, `c_tvalid`, `c_tdata` and `c_tlast` hold their values into the next cycle.
- R6: A run with length N > 0 sends exactly N result beats. `c_tlast` is 1 on beat N-1 and 0 on every other beat. After that beat the control register reads 0x6 (done and idle).
- R7: Writing start while a run is in progress has no effect. The run in progress keeps the length it was started with, even if the length register has since changed.
- R8: A start with a length of 0 completes at once. The control register reads 0x6 and no result beat appears.
- R9: While the block is idle, neither input ready signal goes high, even if both inputs present valid data.
- R10: With both inputs always valid and `c_tready` held high, both variants send one result beat per cycle. The first and last beats of an N-beat run are N-1 cycles apart.
- R11: An accepted start clears the done bit and sets bit 0 (busy), so the control register reads 0x1 during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_awaddr | input | 5 | Control write address |
| ctl_awvalid | input | 1 | Write address valid |
| ctl_awready | output | 1 | Write address ready |
| ctl_wdata | input | 32 | Write data |
| ctl_wvalid | input | 1 | Write data valid |
| ctl_wready | output | 1 | Write data ready |
| ctl_bresp | output | 2 | Write response, always OKAY |
| ctl_bvalid | output | 1 | Write response valid |
| ctl_bready | input | 1 | Write response ready |
| ctl_araddr | input | 5 | Read address |
| ctl_arvalid | input | 1 | Read address valid |
| ctl_arready | output | 1 | Read address ready |
| ctl_rdata | output | 32 | Read data |
| ctl_rresp | output | 2 | Read response, always OKAY |
| ctl_rvalid | output | 1 | Read data valid |
| ctl_rready | input | 1 | Read data ready |
| a_tdata | input | 32 | Operand A stream data |
| a_tvalid | input | 1 | Operand A valid |
| a_tready | output | 1 | Operand A ready |
| b_tdata | input | 32 | Operand B stream data |
| b_tvalid | input | 1 | Operand B valid |
| b_tready | output | 1 | Operand B ready |
| c_tdata | output | 32 | Result stream data |
| c_tvalid | output | 1 | Result valid |
| c_tready | input | 1 | Result ready |
| c_tlast | output | 1 | Marks the final result beat |

## Verification
Two functions can fall in the same cycle: a new operand pair entering the pipeline, and a held result leaving it. This case matters most when the multiply pipeline is full and the output ready signal toggles. The bench creates it by sweeping run lengths against several patterns. In these patterns each input inserts idle cycles of its own, and the output ready follows a separate on/off rhythm. Every beat is checked against a sum or product computed in the bench, and the bench also checks the beat count and the place of TLAST. No beat may be lost, repeated or reordered when the two events coincide.

// File: rtl/elemwise_engine.sv
module elemwise_engine #(
  parameter int  DATA_W  = 32,
  parameter int  ADDR_W  = 5,
  parameter bit  USE_MUL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ctl_awaddr,
  input  logic              ctl_awvalid,
  output logic              ctl_awready,
  input  logic [31:0]       ctl_wdata,
  input  logic              ctl_wvalid,
  output logic              ctl_wready,
  output logic [1:0]        ctl_bresp,
  output logic              ctl_bvalid,
  input  logic              ctl_bready,
  input  logic [ADDR_W-1:0] ctl_araddr,
  input  logic              ctl_arvalid,
  output logic              ctl_arready,
  output logic [31:0]       ctl_rdata,
  output logic [1:0]        ctl_rresp,
  output logic              ctl_rvalid,
  input  logic              ctl_rready,
  input  logic [DATA_W-1:0] a_tdata,
  input  logic              a_tvalid,
  output logic              a_tready,
  input  logic [DATA_W-1:0] b_tdata,
  input  logic              b_tvalid,
  output logic              b_tready,
  output logic [DATA_W-1:0] c_tdata,
  output logic              c_tvalid,
  input  logic              c_tready,
  output logic              c_tlast
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = '0;
  localparam logic [ADDR_W-1:0] LEN_OFS  = ADDR_W'(16);

  logic        busy, done;
  logic [31:0] len_reg, run_len, issued;
  logic        wr_go, rd_go, start_hit, pend, in_adv, out_adv, accept, last_in;

  assign wr_go       = ctl_awvalid && ctl_wvalid && !ctl_bvalid;
  assign ctl_awready = wr_go;
  assign ctl_wready  = wr_go;
  assign ctl_bresp   = 2'b00;
  assign rd_go       = ctl_arvalid && !ctl_rvalid;
  assign ctl_arready = rd_go;
  assign ctl_rresp   = 2'b00;
  assign start_hit   = wr_go && (ctl_awaddr == CTRL_OFS) && ctl_wdata[0] && !busy;

  assign pend     = issued != run_len;
  assign out_adv  = !c_tvalid || c_tready;
  assign a_tready = busy && pend && b_tvalid && in_adv;
  assign b_tready = busy && pend && a_tvalid && in_adv;
  assign accept   = busy && pend && a_tvalid && b_tvalid && in_adv;
  assign last_in  = issued == run_len - 32'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_bvalid <= 1'b0;
      len_reg    <= '0;
    end else begin
      if (wr_go) ctl_bvalid <= 1'b1;
      else if (ctl_bready) ctl_bvalid <= 1'b0;
      if (wr_go && ctl_awaddr == LEN_OFS) len_reg <= ctl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_rvalid <= 1'b0;
      ctl_rdata  <= '0;
    end else if (rd_go) begin
      ctl_rvalid <= 1'b1;
      if (ctl_araddr == LEN_OFS)       ctl_rdata <= len_reg;
      else if (ctl_araddr == CTRL_OFS) ctl_rdata <= {29'd0, !busy, done, busy};
      else                             ctl_rdata <= '0;
    end else if (ctl_rready) begin
      ctl_rvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      run_len <= '0;
      issued  <= '0;
    end else if (start_hit) begin
      run_len <= len_reg;
      issued  <= '0;
      busy    <= len_reg != 32'd0;
      done    <= len_reg == 32'd0;
    end else begin
      if (accept) issued <= issued + 32'd1;
      if (c_tvalid && c_tready && c_tlast) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  generate
    if (USE_MUL) begin : g_mul
      logic              v1, l1;
      logic [DATA_W-1:0] a1, b1;
      assign in_adv = !v1 || out_adv;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v1 <= 1'b0;
          l1 <= 1'b0;
          a1 <= '0;
          b1 <= '0;
        end else if (in_adv) begin
          v1 <= accept;
          l1 <= last_in;
          a1 <= a_tdata;
          b1 <= b_tdata;
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          c_tvalid <= 1'b0;
          c_tlast  <= 1'b0;
          c_tdata  <= '0;
        end else if (out_adv) begin
          c_tvalid <= v1;
          c_tlast  <= l1;
          c_tdata  <= a1 * b1;
        end
      end
    end else begin : g_add
      assign in_adv = out_adv;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          c_tvalid <= 1'b0;
          c_tlast  <= 1'b0;
          c_tdata  <= '0;
        end else if (out_adv) begin
          c_tvalid <= accept;
          c_tlast  <= last_in;
          c_tdata  <= a_tdata + b_tdata;
        end
      end
    end
  endgenerate
endmodule

module elemwise_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              a_tvalid,
  input logic              a_tready,
  input logic              b_tvalid,
  input logic              b_tready,
  input logic [DATA_W-1:0] c_tdata,
  input logic              c_tvalid,
  input logic              c_tready,
  input logic              c_tlast
);
  assert_pair_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tvalid && a_tready) |-> (b_tvalid && b_tready));
  assert_pair_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_tvalid && b_tready) |-> (a_tvalid && a_tready));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_tvalid && !c_tready) |=> (c_tvalid && $stable(c_tdata) && $stable(c_tlast)));
  assert_idle_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!a_tready && !b_tready));
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_tvalid && c_tready && c_tlast) |=> !busy);
endmodule

bind elemwise_engine elemwise_engine_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/elemwise_engine_tb_top.sv
`timescale 1ns/1ps
module elemwise_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  awaddr[2], araddr[2];
  logic        awvalid[2], awready[2], wvalid[2], wready[2], bvalid[2];
  logic        arvalid[2], arready[2], rvalid[2];
  logic [1:0]  bresp[2], rresp[2];
  logic [31:0] wdata[2], rdata[2];
  logic [31:0] a_tdata[2], b_tdata[2], c_tdata[2];
  logic        a_tvalid[2], a_tready[2], b_tvalid[2], b_tready[2];
  logic        c_tvalid[2], c_tready[2], c_tlast[2];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  for (genvar u = 0; u < 2; u++) begin : g_u
    elemwise_engine #(.USE_MUL(u == 1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_awaddr(awaddr[u]), .ctl_awvalid(awvalid[u]), .ctl_awready(awready[u]),
      .ctl_wdata(wdata[u]), .ctl_wvalid(wvalid[u]), .ctl_wready(wready[u]),
      .ctl_bresp(bresp[u]), .ctl_bvalid(bvalid[u]), .ctl_bready(1'b1),
      .ctl_araddr(araddr[u]), .ctl_arvalid(arvalid[u]), .ctl_arready(arready[u]),
      .ctl_rdata(rdata[u]), .ctl_rresp(rresp[u]), .ctl_rvalid(rvalid[u]), .ctl_rready(1'b1),
      .a_tdata(a_tdata[u]), .a_tvalid(a_tvalid[u]), .a_tready(a_tready[u]),
      .b_tdata(b_tdata[u]), .b_tvalid(b_tvalid[u]), .b_tready(b_tready[u]),
      .c_tdata(c_tdata[u]), .c_tvalid(c_tvalid[u]), .c_tready(c_tready[u]), .c_tlast(c_tlast[u])
    );
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] a_val(int seed, int i);
    return 32'(seed) * 32'h9E3779B9 + 32'(i) * 32'h01000193;
  endfunction
  function automatic logic [31:0] b_val(int seed, int i);
    return (32'(seed) ^ 32'hFFFF_FFF0) + 32'(i) * 32'h7FFF_FFFF;
  endfunction
  function automatic logic [31:0] c_val(int u, logic [31:0] a, logic [31:0] b);
    return (u == 1) ? a * b : a + b;
  endfunction

  task automatic axw(int u, logic [4:0] ad, logic [31:0] d);
    @(posedge clk); #1;
    awaddr[u] = ad; wdata[u] = d; awvalid[u] = 1'b1; wvalid[u] = 1'b1;
    do @(negedge clk); while (!awready[u]);
    @(posedge clk); #1;
    awvalid[u] = 1'b0; wvalid[u] = 1'b0;
  endtask

  task automatic axr(int u, logic [4:0] ad, output logic [31:0] d);
    @(posedge clk); #1;
    araddr[u] = ad; arvalid[u] = 1'b1;
    do @(negedge clk); while (!arready[u]);
    @(posedge clk); #1;
    arvalid[u] = 1'b0;
    @(negedge clk);
    d = rdata[u];
  endtask

  task automatic feed(int u, bit side_b, int n, int seed, int gap);
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      int k = (gap == 0) ? 0 : ((i * (gap + side_b) + seed) % 3);
      repeat (k) begin @(posedge clk); #1; end
      if (side_b) begin b_tdata[u] = b_val(seed, i); b_tvalid[u] = 1'b1; end
      else        begin a_tdata[u] = a_val(seed, i); a_tvalid[u] = 1'b1; end
      do @(negedge clk); while (!(side_b ? b_tready[u] : a_tready[u]));
      @(posedge clk); #1;
      if (side_b) b_tvalid[u] = 1'b0; else a_tvalid[u] = 1'b0;
    end
  endtask

  task automatic drain(int u, int n, int seed, int gap);
    int beats = 0;
    int first = -1;
    int lastc = -1;
    bit held = 1'b0;
    logic [31:0] hd = '0;
    for (int cyc = 0; cyc < n * 10 + 40; cyc++) begin
      @(posedge clk); #1;
      c_tready[u] = (gap == 0) ? 1'b1 : (((cyc + seed) % (gap + 1)) != 0);
      @(negedge clk);
      if (held) chk(c_tvalid[u] && c_tdata[u] == hd, "R5 hold", c_tdata[u], hd);
      held = c_tvalid[u] && !c_tready[u];
      hd = c_tdata[u];
      if (c_tvalid[u] && c_tready[u]) begin
        logic [31:0] e = c_val(u, a_val(seed, beats), b_val(seed, beats));
        chk(c_tdata[u] == e, "R3 data", c_tdata[u], e);
        chk(c_tlast[u] == (beats == n - 1), "R6 tlast", 32'(c_tlast[u]), 32'(beats == n - 1));
        if (first < 0) first = cyc;
        lastc = cyc;
        beats++;
      end
    end
    chk(beats == n, "R6 count", beats, n);
    if (gap == 0) chk(lastc - first == n - 1, "R10 rate", lastc - first, n - 1);
    @(posedge clk); #1;
    c_tready[u] = 1'b0;
  endtask

  task automatic run(int u, int n, int seed, int gap);
    logic [31:0] r;
    axw(u, 5'h10, 32'(n));
    axw(u, 5'h00, 32'h1);
    fork
      feed(u, 1'b0, n, seed, gap);
      feed(u, 1'b1, n, seed, gap);
      drain(u, n, seed, gap);
    join
    axr(u, 5'h00, r);
    chk(r == 32'h6, "R6 done", r, 32'h6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int u = 0; u < 2; u++) begin
      awaddr[u] = '0; araddr[u] = '0; wdata[u] = '0;
      awvalid[u] = 1'b0; wvalid[u] = 1'b0; arvalid[u] = 1'b0;
      a_tdata[u] = '0; b_tdata[u] = '0;
      a_tvalid[u] = 1'b0; b_tvalid[u] = 1'b0; c_tready[u] = 1'b0;
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int u = 0; u < 2; u++) begin
      @(negedge clk);
      chk(c_tvalid[u] == 1'b0, "R1 valid", 32'(c_tvalid[u]), 0);
      axr(u, 5'h00, r);
      chk(r == 32'h4, "R1 ctrl", r, 32'h4);

      axw(u, 5'h10, 32'hDEAD_BEEF);
      axr(u, 5'h10, r);
      chk(r == 32'hDEAD_BEEF, "R2 len", r, 32'hDEAD_BEEF);

      // R8 zero length, with both inputs offered while idle (R9)
      axw(u, 5'h10, 32'h0);
      @(posedge clk); #1;
      a_tvalid[u] = 1'b1; b_tvalid[u] = 1'b1; c_tready[u] = 1'b1;
      axw(u, 5'h00, 32'h1);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        chk(!a_tready[u] && !b_tready[u], "R9 idle ready", 32'(a_tready[u]), 0);
        chk(!c_tvalid[u], "R8 no beat", 32'(c_tvalid[u]), 0);
      end
      @(posedge clk); #1;
      a_tvalid[u] = 1'b0; b_tvalid[u] = 1'b0; c_tready[u] = 1'b0;
      axr(u, 5'h00, r);
      chk(r == 32'h6, "R8 done", r, 32'h6);

      for (int n = 1; n <= 6; n++)
        for (int g = 0; g <= 2; g++)
          run(u, n, n * 7 + g + u, g);
      run(u, 8, 99, 0);

      // R7: second start during a run, with LEN changed in between
      axw(u, 5'h10, 32'd4);
      axw(u, 5'h00, 32'h1);
      axr(u, 5'h00, r);
      chk(r == 32'h1, "R11 busy", r, 32'h1);
      @(posedge clk); #1;
      a_tvalid[u] = 1'b1; b_tvalid[u] = 1'b0;
      @(negedge clk);
      chk(!a_tready[u], "R4 lone input", 32'(a_tready[u]), 0);
      @(posedge clk); #1;
      a_tvalid[u] = 1'b0;
      axw(u, 5'h10, 32'd9);
      axw(u, 5'h00, 32'h1);
      fork
        feed(u, 1'b0, 4, 5, 1);
        feed(u, 1'b1, 4, 5, 1);
        drain(u, 4, 5, 1);
      join
      axr(u, 5'h00, r);
      chk(r == 32'h6, "R7 ignored start", r, 32'h6);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule